// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a host-side parallel bus and the operation engine of a byte-wide flash array. It watches write cycles on the bus, each an address plus a data byte, and recognises the multi-cycle unlock sequences of the standard single-supply flash command set. When a sequence completes it raises exactly one single-clock request pulse toward the engine. The pulse carries the latched target address and data byte. The requests are program byte, erase whole array, erase one block and set boot lock.

The block also keeps the read mode. In array mode, host reads come from the storage. In identification mode they return a manufacturer code, a device code and the boot-lock status, which this block produces itself. A write only counts as a bus cycle when the strobe conditions are held for `MIN_PULSE` consecutive clocks, which rejects glitches. While the engine reports busy, every write is dropped and the sequencer keeps its position.

The sequencer states are:
- `ST_IDLE`: waiting for the first unlock byte.
- `ST_UNLK1`: first unlock byte seen.
- `ST_CMD`: both unlock bytes seen, command byte expected.
- `ST_PROG`: program data expected.
- `ST_EUNLK0`: setup byte 80h seen.
- `ST_EUNLK1`: second AAh seen.
- `ST_ECMD`: final erase or lock byte expected.

The transitions are:
- `ST_IDLE` goes to `ST_UNLK1` on AAh@555h. It stays in `ST_IDLE` on anything else; a lone F0h on that path exits identification mode.
- `ST_UNLK1` goes to `ST_CMD` on 55h@2AAh.
- `ST_CMD` goes to `ST_PROG` on A0h@555h and to `ST_EUNLK0` on 80h@555h. On 90h@555h or F0h@555h it sets the mode and returns to `ST_IDLE`.
- `ST_PROG` takes any write and returns to `ST_IDLE`.
- `ST_EUNLK0` goes to `ST_EUNLK1` on AAh@555h.
- `ST_EUNLK1` goes to `ST_ECMD` on 55h@2AAh.
- `ST_ECMD` takes any write and returns to `ST_IDLE`.
- Any mismatch returns to `ST_IDLE`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, all four request outputs are low, `rd_ident` is 0 (array mode) and `id_byte` is 00h.
- R2: A write cycle is taken only when `bus_sel`=1, `bus_wr`=1 and `bus_rd`=0 hold on `MIN_PULSE` consecutive rising edges. Each such assertion yields exactly one cycle, however long it is held, and shorter pulses are discarded.
- R3: The four-cycle sequence AAh@555h, 55h@2AAh, A0h@555h, D@A raises `req_prog` for one clock with `req_addr`=A and `req_data`=D. At most one request output is high in any clock.
- R4: The six-cycle sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raises `req_chip_erase` for one clock, whether or not the boot lock is set.
- R5: The same five-cycle prefix followed by 30h at any address A raises `req_blk_erase` with `req_addr`=A. No request is made when A lies in the boot block and `boot_locked`=1. The boot block is the range whose top `BOOT_W` address bits are all ones when `TOP_BOOT`=1, or all zeros when `TOP_BOOT`=0.
- R6: A program whose target lies in the boot block while `boot_locked`=1 makes no request.
- R7: The five-cycle prefix followed by 40h@555h raises `req_lock_set` for one clock and puts the block in identification mode (`rd_ident`=1).
- R8: 90h@555h after the two unlock cycles sets `rd_ident`=1. In that mode `id_byte` depends on `bus_addr[1:0]`: 0 gives 9Dh, 1 gives 1Dh (`TOP_BOOT`=1) or 2Dh (`TOP_BOOT`=0), 2 gives {7'b0, `boot_locked`}, and 3 gives 00h. In array mode `id_byte` is 00h.
- R9: Array mode is restored either by AAh@555h, 55h@2AAh, F0h@555h, or by a single F0h at any address while the sequencer is idle.
- R10: A write that does not match the expected address and data returns the sequencer to idle without any request. A later sequence must start again from AAh@555h.
- R11: Unlock and command addresses are compared on `bus_addr[10:0]` only; higher address bits are ignored.
- R12: While `eng_busy`=1, every write cycle is ignored: no request is made and the sequence position is kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Device selected (active high) |
| bus_rd | input | 1 | Read/output enable (active high), inhibits writes |
| bus_wr | input | 1 | Write strobe (active high) |
| bus_addr | input | ADDR_W | Bus address, used for writes and identification reads |
| bus_wdata | input | 8 | Write data byte |
| eng_busy | input | 1 | Operation engine busy; writes ignored |
| boot_locked | input | 1 | Boot block lock state from storage |
| req_prog | output | 1 | One-clock program request |
| req_chip_erase | output | 1 | One-clock erase-all request |
| req_blk_erase | output | 1 | One-clock block erase request |
| req_lock_set | output | 1 | One-clock boot-lock set request |
| req_addr | output | ADDR_W | Address that goes with the request |
| req_data | output | 8 | Data byte that goes with the request |
| rd_ident | output | 1 | 1 = identification read mode, 0 = array mode |
| id_byte | output | 8 | Identification read byte |

## Verification
The assertions assume that the bus inputs are synchronous to `clk`, with no undefined values once reset is released. They also assume that `boot_locked` and `eng_busy` change only between write cycles, so that a request can be related to the lock and busy values one clock before it. The bench drives every input on the falling edge and holds `boot_locked` steady across each sequence. It raises or lowers `eng_busy` only while the strobe is idle, so the stimulus stays inside these limits.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_UNLK1  = 3'd1,
        ST_CMD    = 3'd2,
        ST_PROG   = 3'd3,
        ST_EUNLK0 = 3'd4,
        ST_EUNLK1 = 3'd5,
        ST_ECMD   = 3'd6
    } seq_state_e;

    typedef enum logic {
        MODE_ARRAY = 1'b0,
        MODE_IDENT = 1'b1
    } rd_mode_e;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_SETUP    = 8'h80;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_LEAVE    = 8'hF0;
    localparam logic [7:0] OP_ALL      = 8'h10;
    localparam logic [7:0] OP_BLOCK    = 8'h30;
    localparam logic [7:0] OP_LOCK     = 8'h40;

    localparam logic [7:0] MAKER_CODE  = 8'h9D;
    localparam logic [7:0] PART_TOP    = 8'h1D;
    localparam logic [7:0] PART_BOTTOM = 8'h2D;

endpackage

// File: rtl/cmd_wr_filter.sv
module cmd_wr_filter #(
    parameter int ADDR_W    = 18,
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              cyc_vld,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [7:0]        cyc_data
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_PULSE - 1);

    logic             wr_cond;
    logic [CNT_W-1:0] cnt_q;
    logic             fired_q;

    assign wr_cond = bus_sel & bus_wr & ~bus_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            fired_q  <= 1'b0;
            cyc_vld  <= 1'b0;
            cyc_addr <= '0;
            cyc_data <= '0;
        end else begin
            cyc_vld <= 1'b0;
            if (!wr_cond) begin
                cnt_q   <= '0;
                fired_q <= 1'b0;
            end else if (!fired_q) begin
                if (cnt_q == CNT_LAST) begin
                    fired_q  <= 1'b1;
                    cyc_vld  <= 1'b1;
                    cyc_addr <= bus_addr;
                    cyc_data <= bus_wdata;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R2: a cycle is only produced after the strobe condition was present
    assert_cycle_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_vld |-> $past(wr_cond));

    // R2: a held strobe yields a single cycle, never two back to back
    assert_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_vld |=> !cyc_vld);

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int UNLK_W   = 11,
    parameter int BOOT_W   = 4,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_vld,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [7:0]        cyc_data,
    input  logic              eng_busy,
    input  logic              boot_locked,
    output logic              req_prog,
    output logic              req_chip_erase,
    output logic              req_blk_erase,
    output logic              req_lock_set,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_data,
    output logic              rd_ident
);
    localparam logic [UNLK_W-1:0] ADR_KEY1 = UNLK_W'(11'h555);
    localparam logic [UNLK_W-1:0] ADR_KEY2 = UNLK_W'(11'h2AA);

    seq_state_e st_q, st_nx;
    rd_mode_e   mode_q, mode_nx;

    logic              prog_nx, chip_nx, blk_nx, lock_nx;
    logic [ADDR_W-1:0] addr_nx;
    logic [7:0]        data_nx;
    logic              at_key1, at_key2, take, cyc_boot, protect;

    function automatic logic in_boot(input logic [ADDR_W-1:0] a);
        if (TOP_BOOT) return &a[ADDR_W-1 -: BOOT_W];
        else          return ~|a[ADDR_W-1 -: BOOT_W];
    endfunction

    assign at_key1  = (cyc_addr[UNLK_W-1:0] == ADR_KEY1);
    assign at_key2  = (cyc_addr[UNLK_W-1:0] == ADR_KEY2);
    assign take     = cyc_vld & ~eng_busy;
    assign cyc_boot = in_boot(cyc_addr);
    assign protect  = cyc_boot & boot_locked;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            mode_q <= MODE_ARRAY;
        end else begin
            st_q   <= st_nx;
            mode_q <= mode_nx;
        end
    end

    // next state and next outputs
    always_comb begin
        st_nx   = st_q;
        mode_nx = mode_q;
        prog_nx = 1'b0;
        chip_nx = 1'b0;
        blk_nx  = 1'b0;
        lock_nx = 1'b0;
        addr_nx = req_addr;
        data_nx = req_data;
        if (take) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (at_key1 && cyc_data == KEY_FIRST) st_nx = ST_UNLK1;
                    else if (cyc_data == OP_LEAVE)        mode_nx = MODE_ARRAY;
                end
                ST_UNLK1: begin
                    st_nx = (at_key2 && cyc_data == KEY_SECOND) ? ST_CMD : ST_IDLE;
                end
                ST_CMD: begin
                    st_nx = ST_IDLE;
                    if (at_key1) begin
                        case (cyc_data)
                            OP_PROGRAM: st_nx   = ST_PROG;
                            OP_SETUP:   st_nx   = ST_EUNLK0;
                            OP_IDENT:   mode_nx = MODE_IDENT;
                            OP_LEAVE:   mode_nx = MODE_ARRAY;
                            default:    st_nx   = ST_IDLE;
                        endcase
                    end
                end
                ST_PROG: begin
                    st_nx   = ST_IDLE;
                    addr_nx = cyc_addr;
                    data_nx = cyc_data;
                    prog_nx = ~protect;
                end
                ST_EUNLK0: begin
                    st_nx = (at_key1 && cyc_data == KEY_FIRST) ? ST_EUNLK1 : ST_IDLE;
                end
                ST_EUNLK1: begin
                    st_nx = (at_key2 && cyc_data == KEY_SECOND) ? ST_ECMD : ST_IDLE;
                end
                ST_ECMD: begin
                    st_nx   = ST_IDLE;
                    addr_nx = cyc_addr;
                    data_nx = cyc_data;
                    if (cyc_data == OP_BLOCK) begin
                        blk_nx = ~protect;
                    end else if (at_key1 && cyc_data == OP_ALL) begin
                        chip_nx = 1'b1;
                    end else if (at_key1 && cyc_data == OP_LOCK) begin
                        lock_nx = 1'b1;
                        mode_nx = MODE_IDENT;
                    end
                end
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_prog       <= 1'b0;
            req_chip_erase <= 1'b0;
            req_blk_erase  <= 1'b0;
            req_lock_set   <= 1'b0;
            req_addr       <= '0;
            req_data       <= '0;
        end else begin
            req_prog       <= prog_nx;
            req_chip_erase <= chip_nx;
            req_blk_erase  <= blk_nx;
            req_lock_set   <= lock_nx;
            req_addr       <= addr_nx;
            req_data       <= data_nx;
        end
    end

    assign rd_ident = (mode_q == MODE_IDENT);

    logic any_req;
    assign any_req = req_prog | req_chip_erase | req_blk_erase | req_lock_set;

    // R3: never more than one request in a clock
    assert_req_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_prog, req_chip_erase, req_blk_erase, req_lock_set}));

    // R3: every request follows an accepted bus cycle
    assert_req_after_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> $past(cyc_vld));

    // R12: a busy engine never receives a request
    assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> !any_req);

    // R5: a locked boot block is never erased block-wise
    assert_blk_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_blk_erase |-> !($past(boot_locked) && in_boot(req_addr)));

    // R6: a locked boot block is never programmed
    assert_prog_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_prog |-> !($past(boot_locked) && in_boot(req_addr)));

    // R7: setting the lock leaves the block in identification mode
    assert_lock_ident_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_lock_set |-> rd_ident);

endmodule

// File: rtl/cmd_id_lookup.sv
module cmd_id_lookup
    import flash_cmd_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic       rd_ident,
    input  logic [1:0] rd_off,
    input  logic       boot_locked,
    output logic [7:0] id_byte
);
    localparam logic [7:0] PART_CODE = TOP_BOOT ? PART_TOP : PART_BOTTOM;

    always_comb begin
        id_byte = 8'h00;
        if (rd_ident) begin
            unique case (rd_off)
                2'd0: id_byte = MAKER_CODE;
                2'd1: id_byte = PART_CODE;
                2'd2: id_byte = {7'b0, boot_locked};
                2'd3: id_byte = 8'h00;
                default: id_byte = 8'h00;
            endcase
        end
    end

    // R8: outside identification mode the byte stays zero
    always_comb begin
        if (!rd_ident) assert_array_zero_R8: assert (id_byte == 8'h00);
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
    parameter int ADDR_W    = 18,
    parameter int UNLK_W    = 11,
    parameter int BOOT_W    = 4,
    parameter int MIN_PULSE = 3,
    parameter bit TOP_BOOT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              eng_busy,
    input  logic              boot_locked,
    output logic              req_prog,
    output logic              req_chip_erase,
    output logic              req_blk_erase,
    output logic              req_lock_set,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_data,
    output logic              rd_ident,
    output logic [7:0]        id_byte
);
    logic              cyc_vld;
    logic [ADDR_W-1:0] cyc_addr;
    logic [7:0]        cyc_data;

    cmd_wr_filter #(
        .ADDR_W    (ADDR_W),
        .MIN_PULSE (MIN_PULSE)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cyc_vld   (cyc_vld),
        .cyc_addr  (cyc_addr),
        .cyc_data  (cyc_data)
    );

    cmd_seq_fsm #(
        .ADDR_W   (ADDR_W),
        .UNLK_W   (UNLK_W),
        .BOOT_W   (BOOT_W),
        .TOP_BOOT (TOP_BOOT)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cyc_vld        (cyc_vld),
        .cyc_addr       (cyc_addr),
        .cyc_data       (cyc_data),
        .eng_busy       (eng_busy),
        .boot_locked    (boot_locked),
        .req_prog       (req_prog),
        .req_chip_erase (req_chip_erase),
        .req_blk_erase  (req_blk_erase),
        .req_lock_set   (req_lock_set),
        .req_addr       (req_addr),
        .req_data       (req_data),
        .rd_ident       (rd_ident)
    );

    cmd_id_lookup #(
        .TOP_BOOT (TOP_BOOT)
    ) u_id (
        .rd_ident    (rd_ident),
        .rd_off      (bus_addr[1:0]),
        .boot_locked (boot_locked),
        .id_byte     (id_byte)
    );

endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
    localparam int ADDR_W = 18;
    localparam int MINP   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              eng_busy = 1'b0, boot_locked = 1'b0;
    logic              req_prog, req_chip_erase, req_blk_erase, req_lock_set;
    logic [ADDR_W-1:0] req_addr;
    logic [7:0]        req_data;
    logic              rd_ident;
    logic [7:0]        id_byte;

    int n_chk = 0, n_bad = 0;
    int n_prog = 0, n_chip = 0, n_blk = 0, n_lock = 0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic [7:0]        last_data = '0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .MIN_PULSE(MINP), .TOP_BOOT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .eng_busy(eng_busy),
        .boot_locked(boot_locked), .req_prog(req_prog), .req_chip_erase(req_chip_erase),
        .req_blk_erase(req_blk_erase), .req_lock_set(req_lock_set), .req_addr(req_addr),
        .req_data(req_data), .rd_ident(rd_ident), .id_byte(id_byte));

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_prog)       n_prog++;
            if (req_chip_erase) n_chip++;
            if (req_blk_erase)  n_blk++;
            if (req_lock_set)   n_lock++;
            if (req_prog | req_chip_erase | req_blk_erase | req_lock_set) begin
                last_addr = req_addr;
                last_data = req_data;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int hold = MINP,
                      input logic rd = 1'b0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = rd; bus_addr = a; bus_wdata = d;
        repeat (hold) @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic unlock();
        wr(18'h00555, 8'hAA);
        wr(18'h002AA, 8'h55);
    endtask

    task automatic prefix5();
        unlock();
        wr(18'h00555, 8'h80);
        unlock();
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic to_array();
        wr(18'h00000, 8'hF0);
        settle();
    endtask

    task automatic t_reset();
        chk("R1 req_prog", req_prog, 0);
        chk("R1 req_chip_erase", req_chip_erase, 0);
        chk("R1 req_blk_erase", req_blk_erase, 0);
        chk("R1 req_lock_set", req_lock_set, 0);
        chk("R1 rd_ident", rd_ident, 0);
        chk("R1 id_byte", id_byte, 8'h00);
    endtask

    task automatic t_program();
        int p0 = n_prog;
        unlock(); wr(18'h00555, 8'hA0); wr(18'h12345, 8'h5A); settle();
        chk("R3 prog count", n_prog - p0, 1);
        chk("R3 prog addr", last_addr, 18'h12345);
        chk("R3 prog data", last_data, 8'h5A);
    endtask

    task automatic t_chip();
        int c0 = n_chip;
        boot_locked = 1'b1;
        prefix5(); wr(18'h00555, 8'h10); settle();
        chk("R4 chip erase while locked", n_chip - c0, 1);
        boot_locked = 1'b0;
    endtask

    task automatic t_block();
        int b0 = n_blk;
        boot_locked = 1'b1;
        prefix5(); wr(18'h10000, 8'h30); settle();
        chk("R5 block erase count", n_blk - b0, 1);
        chk("R5 block erase addr", last_addr, 18'h10000);
        prefix5(); wr(18'h3C123, 8'h30); settle();
        chk("R5 locked boot block erase blocked", n_blk - b0, 1);
        boot_locked = 1'b0;
        prefix5(); wr(18'h3C123, 8'h30); settle();
        chk("R5 unlocked boot block erase", n_blk - b0, 2);
        chk("R5 boot erase addr", last_addr, 18'h3C123);
    endtask

    task automatic t_prog_locked();
        int p0 = n_prog;
        boot_locked = 1'b1;
        unlock(); wr(18'h00555, 8'hA0); wr(18'h3F000, 8'h11); settle();
        chk("R6 locked boot program blocked", n_prog - p0, 0);
        boot_locked = 1'b0;
        unlock(); wr(18'h00555, 8'hA0); wr(18'h3F000, 8'h11); settle();
        chk("R6 unlocked boot program", n_prog - p0, 1);
    endtask

    task automatic t_lockset();
        int l0 = n_lock;
        prefix5(); wr(18'h00555, 8'h40); settle();
        chk("R7 lock set count", n_lock - l0, 1);
        chk("R7 ident mode after lock", rd_ident, 1);
        bus_addr = 18'h00000; #1;
        chk("R7 id read after lock", id_byte, 8'h9D);
        to_array();
    endtask

    task automatic t_ident();
        unlock(); wr(18'h00555, 8'h90); settle();
        chk("R8 ident mode", rd_ident, 1);
        boot_locked = 1'b1;
        bus_addr = 18'h00000; #1; chk("R8 maker code", id_byte, 8'h9D);
        bus_addr = 18'h00001; #1; chk("R8 part code", id_byte, 8'h1D);
        bus_addr = 18'h3C002; #1; chk("R8 lock status", id_byte, 8'h01);
        bus_addr = 18'h00003; #1; chk("R8 offset 3", id_byte, 8'h00);
        boot_locked = 1'b0;
        bus_addr = 18'h00002; #1; chk("R8 lock status clear", id_byte, 8'h00);
    endtask

    task automatic t_exit();
        unlock(); wr(18'h00555, 8'hF0); settle();
        chk("R9 long exit", rd_ident, 0);
        bus_addr = 18'h00000; #1; chk("R8 array mode id zero", id_byte, 8'h00);
        unlock(); wr(18'h00555, 8'h90); settle();
        chk("R9 re-entry", rd_ident, 1);
        wr(18'h2B7C1, 8'hF0); settle();
        chk("R9 short exit", rd_ident, 0);
    endtask

    task automatic t_mismatch();
        int p0 = n_prog;
        int b0 = n_blk;
        unlock(); wr(18'h00555, 8'h77); wr(18'h00555, 8'hA0); wr(18'h01000, 8'h22); settle();
        chk("R10 bad command byte", n_prog - p0, 0);
        wr(18'h00555, 8'hAA); wr(18'h00123, 8'h55); wr(18'h00555, 8'hA0);
        wr(18'h01000, 8'h22); settle();
        chk("R10 bad unlock address", n_prog - p0, 0);
        unlock(); wr(18'h00555, 8'h80); wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h56);
        wr(18'h10000, 8'h30); settle();
        chk("R10 broken erase prefix", n_blk - b0, 0);
        unlock(); wr(18'h00555, 8'hA0); wr(18'h01001, 8'h33); settle();
        chk("R10 recovery after mismatch", n_prog - p0, 1);
    endtask

    task automatic t_alias();
        int p0 = n_prog;
        wr(18'h3D555, 8'hAA); wr(18'h012AA, 8'h55); wr(18'h1F555, 8'hA0);
        wr(18'h00042, 8'hC3); settle();
        chk("R11 upper address bits ignored", n_prog - p0, 1);
        chk("R11 target address", last_addr, 18'h00042);
    endtask

    task automatic t_glitch();
        int p0 = n_prog;
        wr(18'h00555, 8'hAA, MINP - 1); wr(18'h002AA, 8'h55); wr(18'h00555, 8'hA0);
        wr(18'h00100, 8'h44); settle();
        chk("R2 short pulse rejected", n_prog - p0, 0);
        wr(18'h00555, 8'hAA, MINP, 1'b1); wr(18'h002AA, 8'h55); wr(18'h00555, 8'hA0);
        wr(18'h00100, 8'h44); settle();
        chk("R2 read enable inhibits", n_prog - p0, 0);
        wr(18'h00555, 8'hAA, 12); wr(18'h002AA, 8'h55); wr(18'h00555, 8'hA0);
        wr(18'h00100, 8'h44); settle();
        chk("R2 long pulse counted once", n_prog - p0, 1);
    endtask

    task automatic t_busy();
        int p0 = n_prog;
        int c0 = n_chip;
        unlock();
        eng_busy = 1'b1;
        wr(18'h00555, 8'hA0); wr(18'h00200, 8'h99);
        eng_busy = 1'b0;
        settle();
        chk("R12 no request while busy", n_prog - p0, 0);
        wr(18'h00555, 8'hA0); wr(18'h00201, 8'h98); settle();
        chk("R12 position kept", n_prog - p0, 1);
        chk("R12 target addr", last_addr, 18'h00201);
        prefix5();
        eng_busy = 1'b1;
        wr(18'h00555, 8'h10);
        eng_busy = 1'b0;
        settle();
        chk("R12 erase ignored while busy", n_chip - c0, 0);
        wr(18'h00555, 8'h10); settle();
        chk("R12 erase after busy", n_chip - c0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_program();
        t_chip();
        t_block();
        t_prog_locked();
        t_lockset();
        t_ident();
        t_exit();
        t_mismatch();
        t_alias();
        t_glitch();
        t_busy();
        finish_run();
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule